// File: doc/BRIEF.md
# Command-Triggered Word Block Copier

This block is a small copy engine on a host register port. The host writes a 32-bit command in two 16-bit halves. A write to the upper-half register only stores data. A write to the lower-half register forms the full command and starts it. The command carries an opcode byte and a 24-bit pointer.

When the opcode matches, the engine reads a four-word parameter block from the pointer over a request/acknowledge memory master. If the parameter block carries the copy sub-opcode, the engine moves a run of 16-bit words from a source address to a destination address, one read and then one write per word. `busy` is high from the cycle after an accepted command until the engine returns to idle. While `busy` is high, register writes have no effect.

Top module: `word_copy_engine`

## Requirements
- R1: A register write with `reg_sel`=0 loads bits 31:16 of the command and starts nothing. A write with `reg_sel`=1 supplies bits 15:0 and starts processing, with `busy` high from the next cycle.
- R2: If command bits 31:24 differ from 0x64, the command is dropped: `busy` stays low and no memory request is made.
- R3: For an accepted command, the first four accesses are reads at P, P+2, P+4 and P+6, where P is command bits 23:0. The reads give parameter A bits 31:16, A bits 15:0, B bits 31:16 and B bits 15:0, in that order.
- R4: If A bits 31:24 differ from 0x22, the engine returns to idle after the fourth parameter read and makes no write.
- R5: The source start is A bits 23:0, the destination start is B bits 23:0, and the count N is B bits 31:24.
- R6: The engine copies N+1 words. Each word is one read at the source address followed by one write of that data at the destination address. Both addresses advance by 2 after each word.
- R7: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, from the start of each access until the cycle in which `mem_ack` is high.
- R8: `busy` is low in the cycle after the acknowledge that ends the run. That acknowledge is for the last write, or for the fourth parameter read when the sub-opcode does not match.
- R9: Register writes to either half while `busy` is high are ignored. The stored upper half keeps its value and no new command starts.
- R10: N is unsigned. N=0xFF copies 256 words.
- R11: While reset is applied, `busy` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the upper command half, 1 the lower half and start |
| reg_wdata | input | 16 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access acknowledge |
| busy | output | 1 | Engine active |

## Verification
`busy` is due one cycle after the lower-half write. The first request appears in that same cycle. Each access completes on the clock edge where `mem_ack` is high. The next request or the release of `busy` is visible one cycle later.

The bench drives inputs and acknowledges on the falling edge and samples there too. It tags every acknowledge with its cycle number and then demands `busy` low exactly one cycle after the final acknowledge. Access order and addresses are logged at each acknowledge and compared against a sequence the bench derives from the command and parameter words.

// File: rtl/wcopy_pkg.sv
package wcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAR  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } wc_state_t;

  localparam int unsigned PAR_WORDS = 4;
endpackage

// File: rtl/wcopy_cmd_if.sv
module wcopy_cmd_if #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CMD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              go
);
  logic [DATA_W-1:0] hi_q, hi_d;
  logic              hi_en;

  assign hi_en = reg_wr & ~reg_sel & ~busy;
  assign go    = reg_wr &  reg_sel & ~busy;

  always_comb begin
    hi_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  assign cmd_word = {hi_q, reg_wdata};

  // R9: upper half is frozen while the engine runs
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(hi_q));
endmodule

// File: rtl/wcopy_addr_unit.sv
module wcopy_addr_unit #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_init,
  input  logic [ADDR_W-1:0] dst_init,
  input  logic [CNT_W-1:0]  cnt_init,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              en;

  assign en = load | step;

  always_comb begin
    if (load) begin
      src_d = src_init;
      dst_d = dst_init;
      rem_d = cnt_init;
    end else begin
      src_d = src_q + WORD_BYTES;
      dst_d = dst_q + WORD_BYTES;
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      rem_q <= rem_d;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign last     = (rem_q == '0);

  // R6: after a non-final step both addresses moved by one word
  assert_addr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !last) |=> (src_q - $past(src_q) == WORD_BYTES) && (dst_q - $past(dst_q) == WORD_BYTES));
endmodule

// File: rtl/wcopy_ctrl.sv
module wcopy_ctrl
  import wcopy_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMD_OP = 32'h64,
  parameter int unsigned SUB_OP = 32'h22,
  localparam int unsigned CMD_W = 2 * DATA_W,
  localparam int unsigned OPC_W = CMD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              last,
  output wc_state_t         state,
  output logic [1:0]        par_idx,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] data,
  output logic              load,
  output logic              step,
  output logic [ADDR_W-1:0] src_init,
  output logic [ADDR_W-1:0] dst_init,
  output logic [OPC_W-1:0]  cnt_init
);
  localparam int unsigned STORED = PAR_WORDS - 1;

  wc_state_t          state_q, state_d;
  logic [1:0]         idx_q, idx_d;
  logic [ADDR_W-1:0]  ptr_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  par_q [STORED];
  logic [CMD_W-1:0]   prm_a, prm_b;
  logic               cmd_ok, sub_ok, ptr_en, data_en, cap_en;

  assign cmd_ok = (cmd_word[CMD_W-1 -: OPC_W] == OPC_W'(CMD_OP));
  assign prm_a  = {par_q[0], par_q[1]};
  assign prm_b  = {par_q[2], mem_rdata};
  assign sub_ok = (prm_a[CMD_W-1 -: OPC_W] == OPC_W'(SUB_OP));

  assign src_init = prm_a[ADDR_W-1:0];
  assign dst_init = prm_b[ADDR_W-1:0];
  assign cnt_init = prm_b[CMD_W-1 -: OPC_W];

  assign ptr_en  = (state_q == ST_IDLE) & go & cmd_ok;
  assign data_en = (state_q == ST_RD) & mem_ack;
  assign cap_en  = (state_q == ST_PAR) & mem_ack;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go && cmd_ok) begin
          state_d = ST_PAR;
          idx_d   = 2'd0;
        end
      end
      ST_PAR: begin
        if (mem_ack) begin
          if (idx_q == 2'(PAR_WORDS - 1)) begin
            state_d = sub_ok ? ST_RD : ST_IDLE;
            load    = sub_ok;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      ST_RD: begin
        if (mem_ack) state_d = ST_WR;
      end
      ST_WR: begin
        if (mem_ack) begin
          step    = 1'b1;
          state_d = last ? ST_IDLE : ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= cmd_word[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STORED; k++) par_q[k] <= '0;
    end else if (cap_en) begin
      for (int k = 0; k < STORED; k++)
        if (idx_q == 2'(k)) par_q[k] <= mem_rdata;
    end
  end

  assign state   = state_q;
  assign par_idx = idx_q;
  assign ptr     = ptr_q;
  assign data    = data_q;

  // R2: a command with a foreign opcode leaves the engine idle
  assert_bad_opcode_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go && cmd_word[CMD_W-1 -: OPC_W] != OPC_W'(CMD_OP)) |=> (state_q == ST_IDLE));

  // R8: final write acknowledge returns to idle on the next cycle
  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && mem_ack && last) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/word_copy_engine.sv
module word_copy_engine
  import wcopy_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMD_OP = 32'h64,
  parameter int unsigned SUB_OP = 32'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy
);
  localparam int unsigned CMD_W = 2 * DATA_W;
  localparam int unsigned OPC_W = CMD_W - ADDR_W;

  logic              rst_meta_n, rst_s_n;
  logic [CMD_W-1:0]  cmd_word;
  logic              go, load, step, last;
  wc_state_t         state;
  logic [1:0]        par_idx;
  logic [ADDR_W-1:0] ptr, src_init, dst_init, src_addr, dst_addr;
  logic [OPC_W-1:0]  cnt_init;
  logic [DATA_W-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  wcopy_cmd_if #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_s_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .cmd_word(cmd_word), .go(go)
  );

  wcopy_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OP(CMD_OP), .SUB_OP(SUB_OP)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .go(go), .cmd_word(cmd_word),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .last(last),
    .state(state), .par_idx(par_idx), .ptr(ptr), .data(data),
    .load(load), .step(step), .src_init(src_init), .dst_init(dst_init),
    .cnt_init(cnt_init)
  );

  wcopy_addr_unit #(.ADDR_W(ADDR_W), .CNT_W(OPC_W)) u_addr (
    .clk(clk), .rst_n(rst_s_n), .load(load), .step(step),
    .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
    .src_addr(src_addr), .dst_addr(dst_addr), .last(last)
  );

  always_comb begin
    case (state)
      ST_PAR:  mem_addr = ptr + ADDR_W'({par_idx, 1'b0});
      ST_RD:   mem_addr = src_addr;
      ST_WR:   mem_addr = dst_addr;
      default: mem_addr = '0;
    endcase
  end

  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WR);
  assign mem_wdata = data;
  assign busy      = (state != ST_IDLE);

  // R7: a pending access keeps its request and attributes
  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6: every acknowledged copy read is followed by a write
  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state == ST_RD && mem_ack) |=> (mem_req && mem_we));

  // R1: a start from idle raises busy on the next cycle
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && go && cmd_word[CMD_W-1 -: OPC_W] == OPC_W'(CMD_OP)) |=> busy);
endmodule

// File: tb/word_copy_engine_test.sv
module word_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 2048;
  localparam int NVEC       = 6;
  localparam int LOGMAX     = 1024;

  // vector fields: command, parameter A, parameter B, acknowledge latency
  localparam logic [103:0] VEC [NVEC] = '{
    {32'h6400_0100, 32'h2200_0200, 32'h0300_0400, 8'd0},
    {32'h6400_0120, 32'h2200_0300, 32'h0000_0500, 8'd2},
    {32'h6500_0100, 32'h2200_0200, 32'h0300_0400, 8'd0},
    {32'h6400_0140, 32'h2100_0200, 32'h0300_0400, 8'd1},
    {32'h6400_0160, 32'h2200_0600, 32'h0F00_0700, 8'd1},
    {32'h6400_0180, 32'h2200_0800, 32'hFF00_0A00, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel;
  logic [15:0] reg_wdata;
  logic        mem_req, mem_we, mem_ack, busy;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [MEM_WORDS];
  logic [23:0] log_addr [LOGMAX];
  logic        log_we   [LOGMAX];
  int acc_n, lat, wcnt, cyc, last_ack_cyc, hold_viol;
  int n_chk, n_fail;
  bit done;
  logic        pend;
  logic [23:0] pend_addr;
  logic        pend_we;

  word_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] fill(input int i);
    return 16'((i * 32'h3B1) ^ 32'h5A00);
  endfunction

  // memory model: acknowledges on the falling edge after lat waiting cycles
  always @(negedge clk) begin
    if (pend && (mem_req !== 1'b1 || mem_addr !== pend_addr || mem_we !== pend_we))
      hold_viol = hold_viol + 1;
    mem_ack = 1'b0;
    if (mem_req === 1'b1) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_we) mem[mem_addr[11:1]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[11:1]];
        if (acc_n < LOGMAX) begin
          log_addr[acc_n] = mem_addr;
          log_we[acc_n]   = mem_we;
        end
        acc_n = acc_n + 1;
        last_ack_cyc = cyc;
      end else begin
        wcnt = wcnt + 1;
      end
    end
    pend      = (mem_req === 1'b1) && !mem_ack;
    pend_addr = mem_addr;
    pend_we   = mem_we;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic init_mem(input logic [31:0] cmd, input logic [31:0] pa, input logic [31:0] pb);
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = fill(i);
    mem[cmd[11:1]]     = pa[31:16];
    mem[cmd[11:1] + 1] = pa[15:0];
    mem[cmd[11:1] + 2] = pb[31:16];
    mem[cmd[11:1] + 3] = pb[15:0];
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic run_vec(input logic [31:0] cmd, input logic [31:0] pa,
                         input logic [31:0] pb, input int l);
    bit started, copies;
    int n_words, exp_acc, mism, dmis;
    logic [23:0] ptr, src, dst;
    init_mem(cmd, pa, pb);
    lat = l; wcnt = 0; acc_n = 0;
    started = (cmd[31:24] == 8'h64);
    copies  = started && (pa[31:24] == 8'h22);
    n_words = copies ? int'(pb[31:24]) + 1 : 0;
    exp_acc = started ? 4 + 2 * n_words : 0;
    ptr = cmd[23:0]; src = pa[23:0]; dst = pb[23:0];
    reg_write(1'b0, cmd[31:16]);
    reg_write(1'b1, cmd[15:0]);
    chk(busy == started, "R1/R2", "busy after start write", busy, started);
    if (started) begin
      wait_idle();
      chk(cyc == last_ack_cyc + 1, "R8", "busy release cycle", cyc, last_ack_cyc + 1);
    end else begin
      repeat (4) @(negedge clk);
    end
    chk(acc_n == exp_acc, "R2/R4/R6", "access count", acc_n, exp_acc);
    mism = 0;
    for (int k = 0; k < acc_n && k < LOGMAX && k < exp_acc; k++) begin
      logic [23:0] ea;
      logic ew;
      if (k < 4) begin
        ea = ptr + 24'(2 * k); ew = 1'b0;
      end else begin
        ea = (((k - 4) % 2) == 0) ? src + 24'(2 * ((k - 4) / 2)) : dst + 24'(2 * ((k - 4) / 2));
        ew = ((k - 4) % 2) == 1;
      end
      if (log_addr[k] !== ea || log_we[k] !== ew) mism++;
    end
    chk(mism == 0, "R3/R5/R6", "access sequence mismatches", mism, 0);
    dmis = 0;
    for (int j = 0; j < n_words; j++)
      if (mem[dst[11:1] + 11'(j)] !== fill(int'(src[11:1]) + j)) dmis++;
    chk(dmis == 0, (n_words == 256) ? "R10" : "R5/R6", "destination word mismatches", dmis, 0);
    chk(mem[dst[11:1] + 11'(n_words)] === fill(int'(dst[11:1]) + n_words), "R4/R6",
        "word past destination run", mem[dst[11:1] + 11'(n_words)], fill(int'(dst[11:1]) + n_words));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0; n_fail = 0; done = 0; cyc = 0; last_ack_cyc = 0; hold_viol = 0;
    acc_n = 0; lat = 0; wcnt = 0; pend = 1'b0; pend_addr = '0; pend_we = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11", "busy in reset", busy, 0);
    chk(mem_req == 1'b0, "R11", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][103:72], VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]));

    // R1: upper-half write alone starts nothing
    acc_n = 0;
    reg_write(1'b0, 16'h6400);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && acc_n == 0, "R1", "upper-half write started engine", acc_n, 0);

    // R9 and R7: writes during a slow copy are ignored; requests are held
    init_mem(32'h6400_0100, 32'h2200_0200, 32'h0700_0400);
    lat = 3; wcnt = 0; acc_n = 0; hold_viol = 0;
    reg_write(1'b0, 16'h6400);
    reg_write(1'b1, 16'h0100);
    reg_write(1'b0, 16'h1234);
    reg_write(1'b1, 16'h0100);
    wait_idle();
    chk(acc_n == 4 + 16, "R9", "accesses for one copy with writes while busy", acc_n, 20);
    chk(hold_viol == 0, "R7", "request hold violations", hold_viol, 0);
    acc_n = 0; lat = 0;
    reg_write(1'b1, 16'h0100);
    chk(busy == 1'b1, "R9", "stored upper half kept (restart with lower write)", busy, 1);
    wait_idle();
    chk(acc_n == 20, "R9", "accesses for restarted copy", acc_n, 20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule